// File: doc/BRIEF.md
# Timer Gate Qualifier

This unit decides, cycle by cycle, whether a companion timer may advance. It picks one of four single-bit gate sources, can invert the picked signal, and then uses the result in one of three ways. In plain gating the timer counts while the gate is active. In toggle mode the gate passes through a toggle flip-flop, so counting spans a whole period of the source signal. In single-pulse mode software arms the unit with a GO request, and the unit lets the timer count across exactly one active gate interval. It then drops its busy (GO/DONE) indication and raises an interrupt pulse.

All inputs are synchronous to the system clock. The selected, polarity-corrected gate passes through a configurable number of register stages before it is used. The qualified gate level is reported on `gate_val` as a registered value, so it never shows a combinational glitch. When gating is disabled, the count enable is held high and the timer runs freely.

Top module: `tgate_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `gate_val`, `go_busy` and `gate_irq` are all 0.
- R2: `src_sel` picks the gate source: 0 = `gate_pin`, 1 = `timer_match`, 2 = `cmp1_out`, 3 = `cmp2_out`. With toggle mode off, `gate_val` equals the picked source as it stood SAMPLE_STAGES cycles earlier (1 cycle by default).
- R3: With `gate_pol` = 1, the picked source is inverted before any further use, so `gate_val` shows the complement.
- R4: With `gate_en` = 0, `count_en` is 1 whatever the other inputs are.
- R5: With `gate_en` = 1 and both `toggle_mode` and `single_pulse` at 0, `count_en` equals `gate_val`.
- R6: With `gate_en` = 1 and `toggle_mode` = 1, `gate_val` is the output of a toggle flip-flop. The flip-flop flips one cycle after each 0-to-1 change of the polarity-corrected level.
- R7: The toggle flip-flop is cleared in any cycle in which `toggle_mode` or `gate_en` is 0. So in the first cycle of toggle mode, `gate_val` is 0.
- R8: With `gate_en` = 1 and `single_pulse` = 1, a high `go_set` sets `go_busy` from the next cycle. While armed, `count_en` stays 0 until the first 0-to-1 change of `gate_val`. It is 1 from that cycle for as long as `gate_val` stays 1. With `go_busy` low, `count_en` is 0 in this mode.
- R9: The first cycle with `gate_val` = 0 after counting began ends the acquisition. In the next cycle `go_busy` is 0 and `gate_irq` is 1, and `gate_irq` is high for that one cycle only.
- R10: `go_set` is ignored unless `gate_en` and `single_pulse` are both 1. Leaving that configuration clears `go_busy` in the next cycle without raising `gate_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Enables gating; when 0 the timer counts freely |
| src_sel | input | 2 | Gate source select |
| gate_pol | input | 1 | Inverts the selected source when 1 |
| toggle_mode | input | 1 | Routes the gate through the toggle flip-flop |
| single_pulse | input | 1 | Selects single-pulse acquisition |
| go_set | input | 1 | Request to arm an acquisition |
| gate_pin | input | 1 | Gate source 0: external pin |
| timer_match | input | 1 | Gate source 1: match pulse of another timer |
| cmp1_out | input | 1 | Gate source 2: comparator 1 |
| cmp2_out | input | 1 | Gate source 3: comparator 2 |
| count_en | output | 1 | Count qualifier for the timer |
| gate_val | output | 1 | Registered qualified gate level |
| go_busy | output | 1 | GO/DONE: high while an acquisition is armed or running |
| gate_irq | output | 1 | One-cycle pulse when an acquisition completes |

## Verification
The bench uses the default SAMPLE_STAGES of 1. With this setting every source change reaches `gate_val` in one cycle, so a per-cycle model of the requirements can predict all four outputs on every cycle. It sweeps every source select with both polarities. Each mode combination is driven with pseudo-random source activity, and GO requests are injected at random times. This reaches arming while the gate is already high, back-to-back acquisitions, aborts, and toggle-mode entry and exit.

// File: rtl/tgate_pkg.sv
package tgate_pkg;

    localparam int SRC_SEL_W = 2;

    typedef enum logic [1:0] {
        SP_IDLE   = 2'd0,
        SP_ARMED  = 2'd1,
        SP_ACTIVE = 2'd2
    } sp_state_e;

    typedef struct packed {
        logic cmp2;
        logic cmp1;
        logic match;
        logic pin;
    } gate_src_t;

    function automatic logic pick_src(input gate_src_t s, input logic [SRC_SEL_W-1:0] sel);
        logic r;
        case (sel)
            2'd0:    r = s.pin;
            2'd1:    r = s.match;
            2'd2:    r = s.cmp1;
            default: r = s.cmp2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tgate_select.sv
module tgate_select
    import tgate_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  gate_src_t            src,
    input  logic [SRC_SEL_W-1:0] sel,
    input  logic                 pol,
    output logic                 lvl
);
    logic pol_c;
    assign pol_c = pick_src(src, sel) ^ pol;

    generate
        if (STAGES <= 1) begin : g_one
            logic st_q;
            always_ff @(posedge clk) begin
                if (rst) st_q <= 1'b0;
                else     st_q <= pol_c;
            end
            assign lvl = st_q;
        end else begin : g_chain
            logic [STAGES-1:0] st_q;
            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= {st_q[STAGES-2:0], pol_c};
            end
            assign lvl = st_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tgate_toggle.sv
module tgate_toggle (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic active,
    input  logic tog,
    output logic qual
);
    logic lvl_q;
    logic t_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            t_q   <= 1'b0;
        end else begin
            lvl_q <= lvl;
            if (active && tog) t_q <= t_q ^ (lvl & ~lvl_q);
            else               t_q <= 1'b0;
        end
    end

    assign qual = tog ? t_q : lvl;
endmodule

// File: rtl/tgate_onepulse.sv
module tgate_onepulse
    import tgate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic qual,
    input  logic mode_ok,
    input  logic go,
    output logic ce,
    output logic busy,
    output logic irq
);
    sp_state_e st_q, st_n;
    logic      qual_q;
    logic      rise;
    logic      done;

    assign rise = qual & ~qual_q;
    assign done = mode_ok && (st_q == SP_ACTIVE) && !qual;

    always_comb begin
        st_n = st_q;
        if (!mode_ok) begin
            st_n = SP_IDLE;
        end else begin
            case (st_q)
                SP_IDLE:   if (go)    st_n = SP_ARMED;
                SP_ARMED:  if (rise)  st_n = SP_ACTIVE;
                SP_ACTIVE: if (!qual) st_n = SP_IDLE;
                default:              st_n = SP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SP_IDLE;
            qual_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            st_q   <= st_n;
            qual_q <= qual;
            irq    <= done;
        end
    end

    always_comb begin
        case (st_q)
            SP_ARMED:  ce = rise;
            SP_ACTIVE: ce = qual;
            default:   ce = 1'b0;
        endcase
    end

    assign busy = (st_q != SP_IDLE);
endmodule

// File: rtl/tgate_ctrl.sv
module tgate_ctrl
    import tgate_pkg::*;
#(
    parameter int SAMPLE_STAGES = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gate_en,
    input  logic [SRC_SEL_W-1:0] src_sel,
    input  logic                 gate_pol,
    input  logic                 toggle_mode,
    input  logic                 single_pulse,
    input  logic                 go_set,
    input  logic                 gate_pin,
    input  logic                 timer_match,
    input  logic                 cmp1_out,
    input  logic                 cmp2_out,
    output logic                 count_en,
    output logic                 gate_val,
    output logic                 go_busy,
    output logic                 gate_irq
);
    gate_src_t srcs;
    logic      lvl;
    logic      qual;
    logic      sp_ce;

    assign srcs = '{cmp2: cmp2_out, cmp1: cmp1_out, match: timer_match, pin: gate_pin};

    tgate_select #(.STAGES(SAMPLE_STAGES)) u_sel (
        .clk (clk),
        .rst (rst),
        .src (srcs),
        .sel (src_sel),
        .pol (gate_pol),
        .lvl (lvl)
    );

    tgate_toggle u_tog (
        .clk    (clk),
        .rst    (rst),
        .lvl    (lvl),
        .active (gate_en),
        .tog    (toggle_mode),
        .qual   (qual)
    );

    tgate_onepulse u_sp (
        .clk     (clk),
        .rst     (rst),
        .qual    (qual),
        .mode_ok (gate_en & single_pulse),
        .go      (go_set),
        .ce      (sp_ce),
        .busy    (go_busy),
        .irq     (gate_irq)
    );

    assign gate_val = qual;

    always_comb begin
        if (!gate_en)          count_en = 1'b1;
        else if (single_pulse) count_en = sp_ce;
        else                   count_en = qual;
    end
endmodule

// File: rtl/tgate_ctrl_chk.sv
module tgate_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic gate_en,
    input logic toggle_mode,
    input logic single_pulse,
    input logic count_en,
    input logic gate_val,
    input logic go_busy,
    input logic gate_irq
);
    // R4
    free_run_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_en |-> count_en);

    // R5
    plain_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !single_pulse) |-> (count_en == gate_val));

    // R7
    toggle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (toggle_mode && !$past(toggle_mode)) |-> !gate_val);

    // R8
    idle_block_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_en && single_pulse && !go_busy) |-> !count_en);

    // R9
    irq_done_chk: assert property (@(posedge clk) disable iff (rst)
        gate_irq |-> (!go_busy && $past(go_busy)));

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        gate_irq |=> !gate_irq);

    // R10
    go_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_en && single_pulse) |=> !go_busy);
endmodule

bind tgate_ctrl tgate_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .gate_en      (gate_en),
    .toggle_mode  (toggle_mode),
    .single_pulse (single_pulse),
    .count_en     (count_en),
    .gate_val     (gate_val),
    .go_busy      (go_busy),
    .gate_irq     (gate_irq)
);

// File: tb/tgate_ctrl_tb.sv
module tgate_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gate_en = 0, gate_pol = 0, toggle_mode = 0, single_pulse = 0, go_set = 0;
    logic [1:0] src_sel = 0;
    logic       gate_pin = 0, timer_match = 0, cmp1_out = 0, cmp2_out = 0;
    logic       count_en, gate_val, go_busy, gate_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    // bench model state
    logic m_lvl = 0, m_lvlp = 0, m_t = 0, m_gp = 0, m_irq = 0;
    int   m_st = 0;

    always #10 clk = ~clk;

    tgate_ctrl u_dut (
        .clk(clk), .rst(rst), .gate_en(gate_en), .src_sel(src_sel), .gate_pol(gate_pol),
        .toggle_mode(toggle_mode), .single_pulse(single_pulse), .go_set(go_set),
        .gate_pin(gate_pin), .timer_match(timer_match), .cmp1_out(cmp1_out), .cmp2_out(cmp2_out),
        .count_en(count_en), .gate_val(gate_val), .go_busy(go_busy), .gate_irq(gate_irq)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic src_bit();
        case (src_sel)
            2'd0: return gate_pin;
            2'd1: return timer_match;
            2'd2: return cmp1_out;
            default: return cmp2_out;
        endcase
    endfunction

    // inputs already driven; check outputs, then advance model across the coming edge
    task automatic step(input string req);
        logic q, ce, rise, ok;
        #1;
        q    = toggle_mode ? m_t : m_lvl;
        rise = q & ~m_gp;
        ok   = gate_en & single_pulse;
        if (!gate_en)          ce = 1'b1;
        else if (single_pulse) ce = (m_st == 1) ? rise : (m_st == 2) ? q : 1'b0;
        else                   ce = q;
        chk(req, "gate_val", gate_val, q);
        chk(req, "count_en", count_en, ce);
        chk(req, "go_busy",  go_busy,  m_st != 0);
        chk(req, "gate_irq", gate_irq, m_irq);
        m_irq  = ok && (m_st == 2) && !q;
        if (!ok) m_st = 0;
        else if (m_st == 0) m_st = go_set ? 1 : 0;
        else if (m_st == 1) m_st = rise ? 2 : 1;
        else                m_st = q ? 2 : 0;
        m_t    = (gate_en && toggle_mode) ? (m_t ^ (m_lvl & ~m_lvlp)) : 1'b0;
        m_lvlp = m_lvl;
        m_gp   = q;
        m_lvl  = src_bit() ^ gate_pol;
        @(negedge clk);
    endtask

    task automatic rnd_srcs();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        gate_pin    = lfsr[0];
        timer_match = lfsr[3];
        cmp1_out    = lfsr[6];
        cmp2_out    = lfsr[9];
    endtask

    task automatic run(input string req, input int n, input int go_rate);
        for (int i = 0; i < n; i++) begin
            rnd_srcs();
            go_set = (go_rate > 0) && (lfsr[15:12] < go_rate[3:0]);
            step(req);
        end
        go_set = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) begin
            #1;
            chk("R1", "gate_val", gate_val, 1'b0);
            chk("R1", "go_busy",  go_busy,  1'b0);
            chk("R1", "gate_irq", gate_irq, 1'b0);
            @(negedge clk);
        end
        rst = 0;
        step("R1");

        // plain gating, every source and polarity
        gate_en = 1;
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 2; p++) begin
                src_sel = s[1:0];
                gate_pol = p[0];
                run(p ? "R3" : "R2", 30, 0);
                run("R5", 10, 0);
            end
        end

        // free running with gating off in all mode mixes
        gate_en = 0;
        for (int m = 0; m < 4; m++) begin
            toggle_mode = m[0];
            single_pulse = m[1];
            run("R4", 25, 8);
        end
        single_pulse = 0;

        // toggle mode, entry and exit
        gate_en = 1;
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 2; p++) begin
                src_sel = s[1:0];
                gate_pol = p[0];
                toggle_mode = 0;
                run("R7", 3, 0);
                toggle_mode = 1;
                run("R6", 40, 0);
                gate_en = 0;
                run("R7", 2, 0);
                gate_en = 1;
                run("R6", 20, 0);
            end
        end

        // single-pulse acquisition, plain and toggled
        single_pulse = 1;
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 2; t++) begin
                src_sel = s[1:0];
                toggle_mode = t[0];
                gate_pol = s[0];
                run("R8", 60, 6);
                run("R9", 60, 15);
            end
        end

        // directed single pulse on the pin
        toggle_mode = 0; gate_pol = 0; src_sel = 0;
        gate_pin = 1; timer_match = 0; cmp1_out = 0; cmp2_out = 0;
        step("R8");
        go_set = 1; step("R8"); go_set = 0;
        step("R8"); step("R8");
        gate_pin = 0; step("R8"); step("R8");
        gate_pin = 1; step("R8"); step("R8"); step("R8");
        gate_pin = 0; step("R9"); step("R9"); step("R9");

        // go outside single-pulse configuration, and abort
        single_pulse = 0;
        run("R10", 30, 15);
        single_pulse = 1; gate_pin = 0;
        go_set = 1; step("R10"); go_set = 0; step("R10");
        single_pulse = 0; step("R10"); step("R10");
        single_pulse = 1; gate_en = 0;
        go_set = 1; step("R10"); step("R10");
        go_set = 0; gate_en = 1;
        run("R10", 30, 10);
        gate_en = 0; run("R10", 10, 15);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule